// File: doc/BRIEF.md
# Issue-Slot Wait-State Calculator

This block sits at the issue point of an in-order, GPU-style pipeline and answers a single question for the instruction waiting to issue. How many empty issue slots must come first so that every timing hazard against recently issued work is met? The upstream decoder supplies a descriptor for that instruction: class flags, an optional destination register, up to three source registers, a hardware-register identifier and the number of wait states the instruction itself occupies.

The block keeps a short sliding window of what went into recent issue slots. That includes explicit empty entries for the extra cycles of multi-cycle instructions and for inserted no-ops. Each hazard rule measures how far back its most recent producer sits in the window. The block then reports the largest shortfall across all rules.

The issue logic reads `wait_o` in the same cycle. It then either issues the candidate, which writes it into the window, or inserts a no-op, which adds an empty entry.

Top module: `issue_wait_calc`

## Requirements
- R1: Reset (synchronous, active high) empties the window, so right after reset `wait_o` is 0 for any candidate.
- R2: The window keeps the 5 most recent slots. Distance 0 is the slot just before the candidate. A producer pushed beyond distance 4 no longer causes any wait.
- R3: Issuing a candidate with wait-state count N places it at distance N-1 and fills the nearer N-1 slots with empty entries. N=0 is treated as 1, and N is capped at 5.
- R4: A no-op adds one empty slot. Each no-op therefore moves every producer one step further away, and a pending wait with an unchanged candidate drops by one, stopping at 0.
- R5: A scalar-memory candidate (class bit 1) that reads a scalar register needs 4 - d slots when a vector-ALU instruction (class bit 0) wrote that register at distance d. A register is vector when its ID bit 7 is 1.
- R6: A vector-memory candidate (class bit 2) needs 5 - d slots for a scalar source written by a vector-ALU instruction. Its vector sources never cause this wait.
- R7: A candidate with the data-parallel flag (class bit 3) needs 2 - d slots for any vector source. The writer at distance d may be of any class.
- R8: A lane read/write candidate (class bit 4) needs 4 - d slots only when its lane-select operand is scalar and was written by a vector-ALU instruction. The lane-select operand is source 1, at bits 15:8 of the source bus. Other sources do not count.
- R9: A hardware-register read (class bit 5) needs 2 - d slots after a hardware-register write (class bit 6) with the same 6-bit ID. Writes to other IDs have no effect.
- R10: A hardware-register write needs SETR_WAIT - d slots after a write to the same ID. SETR_WAIT is 1 or 2 by generation and defaults to 2.
- R11: An exception return (class bit 7) needs 1 - d slots after a hardware-register write to the trap-status ID, which defaults to 6. Writes to other IDs have no effect.
- R12: `wait_o` is the maximum over all applicable rules, clamped at 0, and follows the candidate combinationally. A candidate with no class flag set gets 0. A producer that is not a vector-ALU instruction never triggers R5, R6 or R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_cls | input | 8 | Class flags: 0 vector ALU, 1 scalar mem, 2 vector mem, 3 data-parallel, 4 lane r/w, 5 hw-reg read, 6 hw-reg write, 7 exception return |
| cand_dst_vld | input | 1 | Candidate writes a register |
| cand_dst | input | 8 | Destination register ID (bit 7 = vector) |
| cand_src_vld | input | 3 | Per-source valid |
| cand_src | input | 24 | Three source IDs, source k at bits 8k+7:8k |
| cand_hwid | input | 6 | Hardware-register ID |
| cand_ws | input | 3 | Wait states the candidate occupies once issued |
| issue_i | input | 1 | Candidate issues this cycle |
| nop_i | input | 1 | Empty slot inserted this cycle |
| wait_o | output | 3 | Empty slots still required before the candidate |

## Verification
The checker assumes the issue logic never asserts `issue_i` and `nop_i` in the same cycle. It also assumes that an unchanged candidate after a no-op is the same instruction, so its wait should have aged by one. The bench drives every strobe from a task that raises exactly one of them for a single cycle. Each check holds the candidate steady between the negative edge and the sampling point. The sweeps place one producer per rule at every distance from 0 to 6 using no-ops. Separate cases cover long instructions, rule combination and producers of the wrong class, ID or operand slot.

// File: rtl/ihz_pkg.sv
`timescale 1ns/1ps
package ihz_pkg;
  parameter int REG_W  = 8;
  parameter int HWID_W = 6;
  parameter int NCLS   = 8;

  localparam int C_VALU = 0;
  localparam int C_SMEM = 1;
  localparam int C_VMEM = 2;
  localparam int C_DPP  = 3;
  localparam int C_LANE = 4;
  localparam int C_GETR = 5;
  localparam int C_SETR = 6;
  localparam int C_RFE  = 7;

  // One issue slot as remembered by the window; all-zero means empty.
  typedef struct packed {
    logic              valu;
    logic              setr;
    logic              dst_vld;
    logic [REG_W-1:0]  dst;
    logic [HWID_W-1:0] hwid;
  } slot_t;
endpackage

// File: rtl/ihz_window.sv
`timescale 1ns/1ps
module ihz_window
  import ihz_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int WS_W  = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push_ins,
  input  logic            push_gap,
  input  slot_t           ins_slot,
  input  logic [WS_W-1:0] ins_span,
  output slot_t           win_o [DEPTH]
);
  slot_t win_q [DEPTH];
  slot_t win_d [DEPTH];
  int    sp;

  always_comb begin
    sp = int'(ins_span);
    if (sp < 1)     sp = 1;
    if (sp > DEPTH) sp = DEPTH;
    for (int k = 0; k < DEPTH; k++) begin
      win_d[k] = win_q[k];
      if (push_ins) begin
        if (k < sp - 1)       win_d[k] = '0;
        else if (k == sp - 1) win_d[k] = ins_slot;
        else                  win_d[k] = win_q[(k >= sp) ? (k - sp) : 0];
      end else if (push_gap) begin
        if (k == 0) win_d[k] = '0;
        else        win_d[k] = win_q[(k >= 1) ? (k - 1) : 0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) win_q <= '{default: '0};
    else     win_q <= win_d;
  end

  assign win_o = win_q;
endmodule

// File: rtl/ihz_src_hits.sv
`timescale 1ns/1ps
module ihz_src_hits
  import ihz_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic [REG_W-1:0] reg_id,
  input  slot_t            win [DEPTH],
  output logic [DEPTH-1:0] by_valu,
  output logic [DEPTH-1:0] by_any
);
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      by_any[i]  = win[i].dst_vld && (win[i].dst == reg_id);
      by_valu[i] = by_any[i] && win[i].valu;
    end
  end
endmodule

// File: rtl/ihz_hwid_hits.sv
`timescale 1ns/1ps
module ihz_hwid_hits
  import ihz_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic [HWID_W-1:0] hwid,
  input  slot_t             win [DEPTH],
  output logic [DEPTH-1:0]  hit
);
  always_comb begin
    for (int i = 0; i < DEPTH; i++)
      hit[i] = win[i].setr && (win[i].hwid == hwid);
  end
endmodule

// File: rtl/ihz_rule_dist.sv
`timescale 1ns/1ps
module ihz_rule_dist #(
  parameter int DEPTH = 5,
  parameter int WAIT  = 4,
  parameter int CW    = 3
) (
  input  logic [DEPTH-1:0] hit,
  output logic [CW-1:0]    need
);
  // Nearest hit wins: scan far to near so the smallest distance is kept.
  always_comb begin
    need = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (hit[i] && (WAIT > i)) need = CW'(WAIT - i);
  end
endmodule

// File: rtl/issue_wait_calc.sv
`timescale 1ns/1ps
module issue_wait_calc
  import ihz_pkg::*;
#(
  parameter int DEPTH     = 5,
  parameter int NSRC      = 3,
  parameter int WS_W      = 3,
  parameter int SMEM_WAIT = 4,
  parameter int VMEM_WAIT = 5,
  parameter int DPP_WAIT  = 2,
  parameter int LANE_WAIT = 4,
  parameter int GETR_WAIT = 2,
  parameter int SETR_WAIT = 2,
  parameter int RFE_WAIT  = 1,
  parameter int TRAP_HWID = 6,
  parameter int LANE_SEL  = 1,
  localparam int CW       = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCLS-1:0]       cand_cls,
  input  logic                  cand_dst_vld,
  input  logic [REG_W-1:0]      cand_dst,
  input  logic [NSRC-1:0]       cand_src_vld,
  input  logic [NSRC*REG_W-1:0] cand_src,
  input  logic [HWID_W-1:0]     cand_hwid,
  input  logic [WS_W-1:0]       cand_ws,
  input  logic                  issue_i,
  input  logic                  nop_i,
  output logic [CW-1:0]         wait_o
);
  localparam int NRULE = 7;
  localparam int RWAIT [NRULE] = '{SMEM_WAIT, VMEM_WAIT, DPP_WAIT, LANE_WAIT,
                                   GETR_WAIT, SETR_WAIT, RFE_WAIT};

  slot_t win [DEPTH];
  slot_t ins_slot;

  always_comb begin
    ins_slot.valu    = cand_cls[C_VALU];
    ins_slot.setr    = cand_cls[C_SETR];
    ins_slot.dst_vld = cand_dst_vld;
    ins_slot.dst     = cand_dst;
    ins_slot.hwid    = cand_hwid;
  end

  ihz_window #(.DEPTH(DEPTH), .WS_W(WS_W)) u_win (
    .clk      (clk),
    .rst      (rst),
    .push_ins (issue_i),
    .push_gap (nop_i),
    .ins_slot (ins_slot),
    .ins_span (cand_ws),
    .win_o    (win)
  );

  logic [DEPTH-1:0] hv [NSRC];
  logic [DEPTH-1:0] ha [NSRC];

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    ihz_src_hits #(.DEPTH(DEPTH)) u_hits (
      .reg_id  (cand_src[s*REG_W +: REG_W]),
      .win     (win),
      .by_valu (hv[s]),
      .by_any  (ha[s])
    );
  end

  logic [DEPTH-1:0] same_hw, trap_hw;
  localparam logic [HWID_W-1:0] TRAP_ID = HWID_W'(TRAP_HWID);

  ihz_hwid_hits #(.DEPTH(DEPTH)) u_same (.hwid(cand_hwid), .win(win), .hit(same_hw));
  ihz_hwid_hits #(.DEPTH(DEPTH)) u_trap (.hwid(TRAP_ID),   .win(win), .hit(trap_hw));

  logic [DEPTH-1:0] sc_valu, vec_any, lane_hit;

  always_comb begin
    sc_valu = '0;
    vec_any = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (cand_src_vld[s]) begin
        if (cand_src[s*REG_W + REG_W-1]) vec_any = vec_any | ha[s];
        else                             sc_valu = sc_valu | hv[s];
      end
    end
    lane_hit = (cand_src_vld[LANE_SEL] && !cand_src[LANE_SEL*REG_W + REG_W-1])
               ? hv[LANE_SEL] : '0;
  end

  logic [DEPTH-1:0] rhit  [NRULE];
  logic [CW-1:0]    rneed [NRULE];

  always_comb begin
    rhit[0] = cand_cls[C_SMEM] ? sc_valu  : '0;
    rhit[1] = cand_cls[C_VMEM] ? sc_valu  : '0;
    rhit[2] = cand_cls[C_DPP]  ? vec_any  : '0;
    rhit[3] = cand_cls[C_LANE] ? lane_hit : '0;
    rhit[4] = cand_cls[C_GETR] ? same_hw  : '0;
    rhit[5] = cand_cls[C_SETR] ? same_hw  : '0;
    rhit[6] = cand_cls[C_RFE]  ? trap_hw  : '0;
  end

  for (genvar r = 0; r < NRULE; r++) begin : g_rule
    ihz_rule_dist #(.DEPTH(DEPTH), .WAIT(RWAIT[r]), .CW(CW)) u_rule (
      .hit  (rhit[r]),
      .need (rneed[r])
    );
  end

  always_comb begin
    wait_o = '0;
    for (int r = 0; r < NRULE; r++)
      if (rneed[r] > wait_o) wait_o = rneed[r];
  end
endmodule

// File: rtl/ihz_checker.sv
`timescale 1ns/1ps
module ihz_checker
  import ihz_pkg::*;
#(
  parameter int DEPTH = 5,
  parameter int NSRC  = 3,
  parameter int WS_W  = 3,
  parameter int CW    = 3
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NCLS-1:0]       cand_cls,
  input logic                  cand_dst_vld,
  input logic [REG_W-1:0]      cand_dst,
  input logic [NSRC-1:0]       cand_src_vld,
  input logic [NSRC*REG_W-1:0] cand_src,
  input logic [HWID_W-1:0]     cand_hwid,
  input logic [WS_W-1:0]       cand_ws,
  input logic                  issue_i,
  input logic                  nop_i,
  input logic [CW-1:0]         wait_o
);
  logic [NCLS+1+REG_W+NSRC+NSRC*REG_W+HWID_W+WS_W-1:0] cand_bus;
  assign cand_bus = {cand_cls, cand_dst_vld, cand_dst, cand_src_vld,
                     cand_src, cand_hwid, cand_ws};

  // Input rule (R4 context): one strobe per cycle at most.
  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    !(issue_i && nop_i));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> wait_o == '0);

  p_gap_ages_r4: assert property (@(posedge clk) disable iff (rst)
    (nop_i && !issue_i) |=> (!$stable(cand_bus)) ||
      (wait_o == (($past(wait_o) == '0) ? '0 : $past(wait_o) - 1'b1)));

  p_no_class_r12: assert property (@(posedge clk) disable iff (rst)
    (cand_cls == '0) |-> wait_o == '0);

  p_rfe_bound_r11: assert property (@(posedge clk) disable iff (rst)
    (cand_cls == NCLS'(1 << C_RFE)) |-> wait_o <= CW'(1));
endmodule

bind issue_wait_calc ihz_checker #(
  .DEPTH(DEPTH), .NSRC(NSRC), .WS_W(WS_W), .CW(CW)
) u_ihz_chk (.*);

// File: tb/tb_issue_wait_calc.sv
`timescale 1ns/1ps
module tb_issue_wait_calc;
  localparam logic [7:0] VALU = 8'h01, SMEM = 8'h02, VMEM = 8'h04, DPP = 8'h08,
                         LANE = 8'h10, GETR = 8'h20, SETR = 8'h40, RFE = 8'h80;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  cand_cls = '0;
  logic        cand_dst_vld = 1'b0;
  logic [7:0]  cand_dst = '0;
  logic [2:0]  cand_src_vld = '0;
  logic [23:0] cand_src = '0;
  logic [5:0]  cand_hwid = '0;
  logic [2:0]  cand_ws = 3'd1;
  logic        issue_i = 1'b0;
  logic        nop_i = 1'b0;
  logic [2:0]  wait_o;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  issue_wait_calc dut (
    .clk(clk), .rst(rst), .cand_cls(cand_cls), .cand_dst_vld(cand_dst_vld),
    .cand_dst(cand_dst), .cand_src_vld(cand_src_vld), .cand_src(cand_src),
    .cand_hwid(cand_hwid), .cand_ws(cand_ws), .issue_i(issue_i),
    .nop_i(nop_i), .wait_o(wait_o)
  );

  always #2.5 clk = ~clk;

  task automatic setc(input logic [7:0] cls, input logic dv, input logic [7:0] d,
                      input logic [2:0] sv, input logic [23:0] s,
                      input logic [5:0] hw, input logic [2:0] ws);
    cand_cls = cls; cand_dst_vld = dv; cand_dst = d;
    cand_src_vld = sv; cand_src = s; cand_hwid = hw; cand_ws = ws;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic do_issue();
    issue_i = 1'b1;
    @(negedge clk); issue_i = 1'b0;
  endtask

  task automatic do_nops(input int n);
    if (n > 0) begin
      nop_i = 1'b1;
      repeat (n) @(negedge clk);
      nop_i = 1'b0;
    end
  endtask

  task automatic check(input string tag, input int exp);
    #1;
    tests++;
    if (int'(wait_o) != exp) begin
      fails++;
      $display("FAIL %s: wait_o=%0d expected %0d", tag, wait_o, exp);
    end
  endtask

  // Producer / consumer per rule (order: R5 R6 R7 R8 R9 R10 R11)
  task automatic set_prod(input int r);
    case (r)
      0, 1: setc(VALU, 1, 8'h05, 3'b000, 24'h0, 6'd0, 3'd1);
      2:    setc(8'h00, 1, 8'h85, 3'b000, 24'h0, 6'd0, 3'd1);
      3:    setc(VALU, 1, 8'h07, 3'b000, 24'h0, 6'd0, 3'd1);
      4, 5: setc(SETR, 0, 8'h00, 3'b000, 24'h0, 6'd3, 3'd1);
      default: setc(SETR, 0, 8'h00, 3'b000, 24'h0, 6'd6, 3'd1);
    endcase
  endtask

  task automatic set_cons(input int r);
    case (r)
      0: setc(SMEM, 0, 8'h00, 3'b001, 24'h000005, 6'd0, 3'd1);
      1: setc(VMEM, 0, 8'h00, 3'b100, 24'h050000, 6'd0, 3'd1);
      2: setc(VALU | DPP, 0, 8'h00, 3'b010, 24'h008500, 6'd0, 3'd1);
      3: setc(VALU | LANE, 0, 8'h00, 3'b011, 24'h000720, 6'd0, 3'd1);
      4: setc(GETR, 0, 8'h00, 3'b000, 24'h0, 6'd3, 3'd1);
      5: setc(SETR, 0, 8'h00, 3'b000, 24'h0, 6'd3, 3'd1);
      default: setc(RFE, 0, 8'h00, 3'b000, 24'h0, 6'd0, 3'd1);
    endcase
  endtask

  initial begin
    int    rw [7]  = '{4, 5, 2, 4, 2, 2, 1};
    string rtg [7] = '{"R5", "R6", "R7", "R8", "R9", "R10", "R11"};

    do_reset();
    // R1: empty window after reset
    set_cons(0); check("R1 empty", 0);
    set_prod(1); do_issue(); do_reset();
    set_cons(1); check("R1 cleared", 0);

    // Per-rule distance sweeps (R2 R4 and R5..R11)
    for (int r = 0; r < 7; r++) begin
      for (int k = 0; k <= 6; k++) begin
        do_reset();
        set_prod(r); do_issue();
        do_nops(k);
        set_cons(r);
        check($sformatf("%s/R4 gap=%0d", rtg[r], k), (rw[r] > k) ? rw[r] - k : 0);
      end
    end

    // R3: multi-cycle producer spans
    do_reset(); setc(VALU, 1, 8'h05, 3'b000, 24'h0, 6'd0, 3'd3); do_issue();
    set_cons(1); check("R3 span3", 3);
    do_reset(); setc(VALU, 1, 8'h05, 3'b000, 24'h0, 6'd0, 3'd0); do_issue();
    set_cons(1); check("R3 span0", 5);
    do_reset(); setc(VALU, 1, 8'h05, 3'b000, 24'h0, 6'd0, 3'd7); do_issue();
    set_cons(1); check("R3 span7 capped", 1);
    // R2: span pushes an older producer out of the window
    do_reset(); set_prod(1); do_issue();
    setc(8'h00, 0, 8'h00, 3'b000, 24'h0, 6'd0, 3'd5); do_issue();
    set_cons(1); check("R2 discard", 0);

    // R6: vector source ignored for the memory rule
    do_reset(); setc(VALU, 1, 8'h85, 3'b000, 24'h0, 6'd0, 3'd1); do_issue();
    setc(VMEM, 0, 8'h00, 3'b001, 24'h000085, 6'd0, 3'd1); check("R6 vector src", 0);
    // R12: non-VALU producer does not trigger scalar-memory rule
    do_reset(); setc(SMEM, 1, 8'h05, 3'b000, 24'h0, 6'd0, 3'd1); do_issue();
    set_cons(0); check("R12 non-valu writer", 0);
    // R12: no class flags -> 0
    do_reset(); set_prod(1); do_issue();
    setc(8'h00, 0, 8'h00, 3'b001, 24'h000005, 6'd0, 3'd1); check("R12 no class", 0);
    // R8: match only on source 0 does not count
    do_reset(); set_prod(3); do_issue();
    setc(VALU | LANE, 0, 8'h00, 3'b011, 24'h002007, 6'd0, 3'd1); check("R8 src0 only", 0);
    // R9: different hardware-register ID
    do_reset(); set_prod(4); do_issue();
    setc(GETR, 0, 8'h00, 3'b000, 24'h0, 6'd4, 3'd1); check("R9 other id", 0);
    // R11: write to non-trap ID
    do_reset(); setc(SETR, 0, 8'h00, 3'b000, 24'h0, 6'd3, 3'd1); do_issue();
    set_cons(6); check("R11 other id", 0);
    // R12: maximum over two rules
    do_reset(); set_prod(1); do_issue();
    setc(VALU, 1, 8'h86, 3'b000, 24'h0, 6'd0, 3'd1); do_issue();
    setc(VALU | VMEM | DPP, 0, 8'h00, 3'b011, 24'h008605, 6'd0, 3'd1);
    check("R12 max of rules", 4);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule